// File: doc/BRIEF.md
# Variant-Selectable Memory Access Checker

The block checks every memory request against one of three fixed rule sets (variants A, B and C) before the access goes ahead. Each request carries an address, a size, an access kind, the variant select, an exception-mask bit and a bit that enables a reserved window. From these the block returns a corrected address and a fault vector. The vector has at most one bit set, and that bit names the fault class found: misaligned, data access error, data access exception, store error, instruction access error or instruction access exception.

Each request goes through two evaluations in a fixed order. The first is the rule for the request's kind (data read, data write or instruction fetch). For data accesses, a common read/write rule then runs on the address that the first rule returned. The result is held in a single register stage. Requests and responses use valid/ready handshakes, so the block can sit inline in a load/store or fetch path that accepts back-pressure.

Top module: `mem_access_guard`

## Requirements
- R1: A request accepted at a clock edge (req_valid and req_ready both high) produces rsp_valid at the next edge. req_ready is high whenever no response is pending or the pending one is being taken (rsp_ready high). While rsp_valid is high and rsp_ready is low, rsp_addr and rsp_fault stay unchanged.
- R2: After reset rsp_valid is low and rsp_fault is zero. rsp_fault is zero in every cycle in which rsp_valid is low.
- R3: rsp_fault bits are: bit0 misaligned, bit1 data access error, bit2 data access exception, bit3 store error, bit4 instruction access error, bit5 instruction access exception. At most one bit is set. A fault from the kind rule takes precedence over a fault from the common rule. Encodings are: req_size is log2 of the byte count (0 is 1 byte, 1 is 2, 2 is 4, 3 is 8, 4 or more is 16), and the alignment mask is the byte count minus one. req_kind is 0 read, 1 write, 2 fetch, 3 none. req_variant is 0 A, 1 B, 2 C, 3 none.
- R4: Variant A read: only an 8-byte access is checked. If its address lies in 0xFE800000..0xFEFFFFFF, the block flags a data access error.
- R5: Variant A common rule (reads and writes): a misaligned address flags a data access error unless req_emask is 1. In both cases the low address bits are cleared in rsp_addr.
- R6: Variant B read: a misaligned address flags misaligned and its low bits are cleared. The corrected address is then checked against 0xFEFF0600..0xFEFF7FFF and 0xFE800000..0xFEFEFFFF, and a hit is a data access error.
- R7: Variant B common rule: an address in 0xFE000000..0xFE7FFFFF flags a data access exception.
- R8: Variant C read: 0xFE800000..0xFEFEFFFF is always a data access error. 0xFEFF0000..0xFEFFFFFF is a data access error only for accesses wider than 4 bytes.
- R9: Variant C common rule: 0xFE000000..0xFE3FFFFF and 0xFE408000..0xFE7FFFFF flag a data access exception. 0xFE400000..0xFE407FFF flags one only when req_rme is 0. The address is never aligned.
- R10: Writes use the read windows and the read alignment policy of their variant, but a window hit is reported as a store error instead of a data access error.
- R11: Variant A fetch: a misaligned address flags an instruction access error and is aligned. Otherwise 0xFE800000..0xFEFFFFFF flags an instruction access error.
- R12: Variant B fetch: misalignment is flagged as misaligned and the address is aligned. The corrected address is then checked in this order: 0xFEFF0600..0xFEFF7FFF or 0xFE800000..0xFEFEFFFF gives an instruction access error; otherwise 0xFE004000..0xFE7FFFFF gives an instruction access exception; otherwise 0xFE000000..0xFE003FFF gives one only when req_rme is 0.
- R13: Variant C fetch: the address is always aligned with no fault for that. Then 0xFE800000..0xFEFFFFFF is an instruction access error; otherwise 0xFE008000..0xFE7FFFFF is an instruction access exception; otherwise 0xFE000000..0xFE007FFF is one only when req_rme is 0.
- R14: With variant 3 or kind 3, the address passes through unchanged and no fault is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 32 | Access address |
| req_size | input | 3 | log2 of the access byte count |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 none |
| req_variant | input | 2 | 0 A, 1 B, 2 C, 3 none |
| req_emask | input | 1 | Suppresses the variant A misalignment error |
| req_rme | input | 1 | Enables the reserved window (no fault there when 1) |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken this cycle |
| rsp_addr | output | 32 | Corrected address |
| rsp_fault | output | 6 | Fault vector, at most one bit set |

## Verification
The hardest cases to reach are collisions between the two rules and between overlapping windows. Examples are a variant B access that is both misaligned and inside an error window, a variant A write that misses the 8-byte store window but is then caught by the common alignment rule, and reserved-window addresses whose outcome flips with req_rme. Directed vectors place addresses on both sides of every window edge, with each size, kind and RME setting that changes the outcome. A randomized phase then draws addresses from offsets around those same edges, with random back-pressure on rsp_ready so that held responses are also compared.

// File: rtl/mag_pkg.sv
package mag_pkg;
  localparam int ADDR_W   = 32;
  localparam int SIZE_W   = 3;
  localparam int FLT_W    = 6;
  localparam int MAX_LOG2 = 4;

  localparam int FB_MIS   = 0;
  localparam int FB_DERR  = 1;
  localparam int FB_DEXC  = 2;
  localparam int FB_STERR = 3;
  localparam int FB_IERR  = 4;
  localparam int FB_IEXC  = 5;

  typedef enum logic [1:0] {K_READ = 2'd0, K_WRITE = 2'd1, K_FETCH = 2'd2, K_NONE = 2'd3} kind_e;
  typedef enum logic [1:0] {V_A = 2'd0, V_B = 2'd1, V_C = 2'd2, V_OFF = 2'd3} var_e;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [FLT_W-1:0]  flt_t;

  typedef struct packed {
    addr_t addr;
    flt_t  fault;
  } chk_t;

  function automatic flt_t fbit(input int b);
    flt_t f;
    f = '0;
    f[b] = 1'b1;
    return f;
  endfunction

  function automatic logic in_win(input addr_t a, input addr_t lo, input addr_t hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic addr_t size_mask(input logic [SIZE_W-1:0] s);
    int n;
    n = (int'(s) > MAX_LOG2) ? MAX_LOG2 : int'(s);
    return addr_t'((1 << n) - 1);
  endfunction

  function automatic flt_t window_fault(input kind_e k);
    case (k)
      K_WRITE: return fbit(FB_STERR);
      K_FETCH: return fbit(FB_IERR);
      default: return fbit(FB_DERR);
    endcase
  endfunction
endpackage

// File: rtl/mag_kind_check.sv
module mag_kind_check
  import mag_pkg::*;
#(
  parameter int NVAR = 3
) (
  input  addr_t addr_i,
  input  addr_t mask_i,
  input  kind_e kind_i,
  input  var_e  var_i,
  input  logic  rme_i,
  output chk_t  res_o
);
  chk_t per_var [NVAR];

  function automatic chk_t rule(input int v, input addr_t a, input addr_t m,
                                input kind_e k, input logic rme);
    chk_t  r;
    logic  mis;
    flt_t  ef;
    r.addr  = a;
    r.fault = '0;
    mis     = |(a & m);
    ef      = window_fault(k);
    case (v)
      0: begin
        if (k == K_FETCH) begin
          if (mis) begin
            r.fault = ef;
            r.addr  = a & ~m;
          end else if (in_win(a, 32'hFE80_0000, 32'hFEFF_FFFF)) begin
            r.fault = ef;
          end
        end else if (m == addr_t'(7) && in_win(a, 32'hFE80_0000, 32'hFEFF_FFFF)) begin
          r.fault = ef;
        end
      end
      1: begin
        if (mis) begin
          r.fault = fbit(FB_MIS);
          r.addr  = a & ~m;
        end
        if (r.fault == '0) begin
          if (in_win(r.addr, 32'hFEFF_0600, 32'hFEFF_7FFF) ||
              in_win(r.addr, 32'hFE80_0000, 32'hFEFE_FFFF))
            r.fault = ef;
          else if (k == K_FETCH && in_win(r.addr, 32'hFE00_4000, 32'hFE7F_FFFF))
            r.fault = fbit(FB_IEXC);
          else if (k == K_FETCH && !rme && in_win(r.addr, 32'hFE00_0000, 32'hFE00_3FFF))
            r.fault = fbit(FB_IEXC);
        end
      end
      default: begin
        if (k == K_FETCH) begin
          r.addr = a & ~m;
          if (in_win(r.addr, 32'hFE80_0000, 32'hFEFF_FFFF))
            r.fault = ef;
          else if (in_win(r.addr, 32'hFE00_8000, 32'hFE7F_FFFF))
            r.fault = fbit(FB_IEXC);
          else if (!rme && in_win(r.addr, 32'hFE00_0000, 32'hFE00_7FFF))
            r.fault = fbit(FB_IEXC);
        end else if (in_win(a, 32'hFE80_0000, 32'hFEFE_FFFF) ||
                     (m > addr_t'(3) && in_win(a, 32'hFEFF_0000, 32'hFEFF_FFFF))) begin
          r.fault = ef;
        end
      end
    endcase
    return r;
  endfunction

  for (genvar v = 0; v < NVAR; v++) begin : g_var
    assign per_var[v] = rule(v, addr_i, mask_i, kind_i, rme_i);
  end

  always_comb begin
    res_o.addr  = addr_i;
    res_o.fault = '0;
    if (kind_i != K_NONE) begin
      case (var_i)
        V_A:     res_o = per_var[0];
        V_B:     res_o = per_var[1];
        V_C:     res_o = per_var[2];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mag_common_check.sv
module mag_common_check
  import mag_pkg::*;
#(
  parameter int NVAR = 3
) (
  input  addr_t addr_i,
  input  addr_t mask_i,
  input  kind_e kind_i,
  input  var_e  var_i,
  input  logic  emask_i,
  input  logic  rme_i,
  output chk_t  res_o
);
  chk_t per_var [NVAR];

  function automatic chk_t rule(input int v, input addr_t a, input addr_t m,
                                input logic emask, input logic rme);
    chk_t r;
    r.addr  = a;
    r.fault = '0;
    case (v)
      0: begin
        if (|(a & m)) begin
          if (!emask) r.fault = fbit(FB_DERR);
          r.addr = a & ~m;
        end
      end
      1: begin
        if (in_win(a, 32'hFE00_0000, 32'hFE7F_FFFF)) r.fault = fbit(FB_DEXC);
      end
      default: begin
        if (in_win(a, 32'hFE00_0000, 32'hFE3F_FFFF) || in_win(a, 32'hFE40_8000, 32'hFE7F_FFFF))
          r.fault = fbit(FB_DEXC);
        else if (!rme && in_win(a, 32'hFE40_0000, 32'hFE40_7FFF))
          r.fault = fbit(FB_DEXC);
      end
    endcase
    return r;
  endfunction

  for (genvar v = 0; v < NVAR; v++) begin : g_var
    assign per_var[v] = rule(v, addr_i, mask_i, emask_i, rme_i);
  end

  always_comb begin
    res_o.addr  = addr_i;
    res_o.fault = '0;
    if (kind_i == K_READ || kind_i == K_WRITE) begin
      case (var_i)
        V_A:     res_o = per_var[0];
        V_B:     res_o = per_var[1];
        V_C:     res_o = per_var[2];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mag_resp_stage.sv
module mag_resp_stage
  import mag_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  output logic  in_ready,
  input  chk_t  in_res,
  output logic  out_valid,
  input  logic  out_ready,
  output addr_t out_addr,
  output flt_t  out_fault
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_fault <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr  <= in_res.addr;
        out_fault <= in_res.fault;
      end else begin
        out_fault <= '0;
      end
    end
  end
endmodule

// File: rtl/mem_access_guard.sv
module mem_access_guard
  import mag_pkg::*;
#(
  parameter int NVAR = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_variant,
  input  logic              req_emask,
  input  logic              req_rme,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [FLT_W-1:0]  rsp_fault
);
  addr_t mask_w;
  kind_e kind_w;
  var_e  var_w;
  chk_t  kind_res;
  chk_t  common_res;
  chk_t  merged_res;
  flt_t  kind_fault;
  flt_t  common_fault;

  assign mask_w = size_mask(req_size);
  assign kind_w = kind_e'(req_kind);
  assign var_w  = var_e'(req_variant);

  mag_kind_check #(.NVAR(NVAR)) kind_i (
    .addr_i (req_addr),
    .mask_i (mask_w),
    .kind_i (kind_w),
    .var_i  (var_w),
    .rme_i  (req_rme),
    .res_o  (kind_res)
  );

  mag_common_check #(.NVAR(NVAR)) common_i (
    .addr_i  (kind_res.addr),
    .mask_i  (mask_w),
    .kind_i  (kind_w),
    .var_i   (var_w),
    .emask_i (req_emask),
    .rme_i   (req_rme),
    .res_o   (common_res)
  );

  assign kind_fault   = kind_res.fault;
  assign common_fault = common_res.fault;

  always_comb begin
    merged_res.addr  = common_res.addr;
    merged_res.fault = (|kind_fault) ? kind_fault : common_fault;
  end

  mag_resp_stage resp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_res    (merged_res),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_addr  (rsp_addr),
    .out_fault (rsp_fault)
  );
endmodule

// File: rtl/mag_guard_checker.sv
module mag_guard_checker
  import mag_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [SIZE_W-1:0] req_size,
  input logic [1:0]        req_kind,
  input logic [1:0]        req_variant,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic [FLT_W-1:0]  rsp_fault
);
  logic took;
  assign took = req_valid && req_ready;

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> rsp_valid); // R1
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_fault))); // R1
  AST_IDLE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_fault == '0)); // R2
  AST_FAULT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_fault)); // R3
  AST_A_DATA_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (took && req_variant == 2'd0 && (req_kind == 2'd0 || req_kind == 2'd1))
    |=> ((rsp_addr & size_mask($past(req_size))) == '0)); // R5
  AST_C_DATA_UNALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (took && req_variant == 2'd2 && (req_kind == 2'd0 || req_kind == 2'd1))
    |=> (rsp_addr == $past(req_addr))); // R9
  AST_STORE_ONLY_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (took && req_kind != 2'd1) |=> !rsp_fault[FB_STERR]); // R10
  AST_C_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (took && req_variant == 2'd2 && req_kind == 2'd2)
    |=> ((rsp_addr & size_mask($past(req_size))) == '0)); // R13
  AST_OFF_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (took && (req_variant == 2'd3 || req_kind == 2'd3))
    |=> (rsp_addr == $past(req_addr) && rsp_fault == '0)); // R14
endmodule

bind mem_access_guard mag_guard_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_addr    (req_addr),
  .req_size    (req_size),
  .req_kind    (req_kind),
  .req_variant (req_variant),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_addr    (rsp_addr),
  .rsp_fault   (rsp_fault)
);

// File: tb/mem_access_guard_tb_top.sv
`timescale 1ns/1ps
module mem_access_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_size = '0;
  logic [1:0]  req_kind = '0;
  logic [1:0]  req_variant = '0;
  logic        req_emask = 1'b0;
  logic        req_rme = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_addr;
  logic [5:0]  rsp_fault;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  bit rand_bp = 0;

  logic [31:0] q_addr[$];
  logic [5:0]  q_fault[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  mem_access_guard dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_kind(req_kind),
    .req_variant(req_variant), .req_emask(req_emask), .req_rme(req_rme),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_fault(rsp_fault)
  );

  function automatic bit w(input logic [31:0] a, input logic [31:0] lo, input logic [31:0] hi);
    return a >= lo && a <= hi;
  endfunction

  // Independent restatement of the rule sets: bytes, error class, then rules in order.
  task automatic model(input logic [31:0] a, input logic [2:0] sz, input logic [1:0] k,
                       input logic [1:0] v, input bit em, input bit rme,
                       output logic [31:0] ca, output logic [5:0] f);
    int bytes;
    logic [31:0] lowm;
    logic [5:0] f1, f2, ecls;
    bytes = (sz >= 3'd4) ? 16 : (1 << sz);
    lowm  = bytes - 1;
    ca = a; f1 = 0; f2 = 0;
    ecls = (k == 2'd1) ? 6'b001000 : (k == 2'd2) ? 6'b010000 : 6'b000010;
    if (v != 2'd3 && k != 2'd3) begin
      if (v == 2'd0) begin
        if (k == 2'd2) begin
          if ((ca & lowm) != 0) begin f1 = ecls; ca = ca & ~lowm; end
          else if (w(ca, 32'hFE800000, 32'hFEFFFFFF)) f1 = ecls;
        end else if (bytes == 8 && w(ca, 32'hFE800000, 32'hFEFFFFFF)) f1 = ecls;
      end else if (v == 2'd1) begin
        if ((ca & lowm) != 0) begin f1 = 6'b000001; ca = ca & ~lowm; end
        if (f1 == 0) begin
          if (w(ca, 32'hFE800000, 32'hFEFEFFFF) || w(ca, 32'hFEFF0600, 32'hFEFF7FFF)) f1 = ecls;
          else if (k == 2'd2 && w(ca, 32'hFE004000, 32'hFE7FFFFF)) f1 = 6'b100000;
          else if (k == 2'd2 && !rme && w(ca, 32'hFE000000, 32'hFE003FFF)) f1 = 6'b100000;
        end
      end else begin
        if (k == 2'd2) begin
          ca = ca & ~lowm;
          if (w(ca, 32'hFE800000, 32'hFEFFFFFF)) f1 = ecls;
          else if (w(ca, 32'hFE008000, 32'hFE7FFFFF)) f1 = 6'b100000;
          else if (!rme && w(ca, 32'hFE000000, 32'hFE007FFF)) f1 = 6'b100000;
        end else if (w(ca, 32'hFE800000, 32'hFEFEFFFF) ||
                     (bytes > 4 && w(ca, 32'hFEFF0000, 32'hFEFFFFFF))) f1 = ecls;
      end
      if (k != 2'd2) begin
        if (v == 2'd0) begin
          if ((ca & lowm) != 0) begin
            if (!em) f2 = 6'b000010;
            ca = ca & ~lowm;
          end
        end else if (v == 2'd1) begin
          if (w(ca, 32'hFE000000, 32'hFE7FFFFF)) f2 = 6'b000100;
        end else begin
          if (w(ca, 32'hFE000000, 32'hFE3FFFFF) || w(ca, 32'hFE408000, 32'hFE7FFFFF)) f2 = 6'b000100;
          else if (!rme && w(ca, 32'hFE400000, 32'hFE407FFF)) f2 = 6'b000100;
        end
      end
    end
    f = (f1 != 0) ? f1 : f2;
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] v, input logic [1:0] k, input logic [2:0] sz,
                      input logic [31:0] a, input bit em, input bit rme, input string tag);
    logic [31:0] ea;
    logic [5:0] ef;
    @(negedge clk);
    req_valid = 1'b1; req_variant = v; req_kind = k; req_size = sz;
    req_addr = a; req_emask = em; req_rme = rme;
    while (!req_ready) @(negedge clk);
    model(a, sz, k, v, em, rme, ea, ef);
    q_addr.push_back(ea); q_fault.push_back(ef); q_tag.push_back(tag);
  endtask

  task automatic idle_req();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: compares every handshaked response and checks stalled holds and idle flags.
  logic [31:0] held_addr;
  logic [5:0]  held_fault;
  bit          was_stalled = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (was_stalled) begin
        check(rsp_valid && rsp_addr == held_addr && rsp_fault == held_fault, "R1 hold",
              {26'd0, rsp_fault, rsp_addr}, {26'd0, held_fault, held_addr});
      end
      was_stalled = rsp_valid && !rsp_ready;
      held_addr = rsp_addr; held_fault = rsp_fault;
      if (!rsp_valid && rsp_fault != 0)
        check(1'b0, "R2 idle flags", {58'd0, rsp_fault}, 64'd0);
      if (rsp_valid && rsp_ready) begin
        if (q_addr.size() == 0) begin
          check(1'b0, "R1 unexpected response", {32'd0, rsp_addr}, 64'd0);
        end else begin
          logic [31:0] ea;
          logic [5:0] ef;
          string t;
          ea = q_addr.pop_front(); ef = q_fault.pop_front(); t = q_tag.pop_front();
          check(rsp_addr == ea && rsp_fault == ef, t,
                {26'd0, rsp_fault, rsp_addr}, {26'd0, ef, ea});
        end
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rand_bp) rsp_ready = ($urandom_range(0, 2) != 0);
    else rsp_ready = 1'b1;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] bases [12];
    bases = '{32'hFE000000, 32'hFE004000, 32'hFE008000, 32'hFE400000, 32'hFE408000,
              32'hFE800000, 32'hFEFF0000, 32'hFEFF0600, 32'hFEFF8000, 32'hFF000000,
              32'h00001000, 32'hFE3FF000};
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0 && rsp_fault == 6'd0, "R2 reset",
          {57'd0, rsp_valid, rsp_fault}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", {63'd0, req_ready}, 64'd1);

    // R1 latency: one request into an idle block shows up at the next edge
    req_valid = 1'b1; req_variant = 2'd3; req_kind = 2'd0; req_size = 3'd2;
    req_addr = 32'h12345678; req_emask = 0; req_rme = 0;
    q_addr.push_back(32'h12345678); q_fault.push_back(6'd0); q_tag.push_back("R1 latency data");
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1, "R1 latency", {63'd0, rsp_valid}, 64'd1);
    @(negedge clk);
    check(rsp_valid == 1'b0 && rsp_fault == 0, "R2 drained", {57'd0, rsp_valid, rsp_fault}, 64'd0);

    // R4
    send(0, 0, 3, 32'hFE800000, 0, 0, "R4 8B low edge");
    send(0, 0, 2, 32'hFE800000, 0, 0, "R4 4B unchecked");
    send(0, 0, 3, 32'hFEFFFFF8, 0, 0, "R4 8B high edge");
    send(0, 0, 3, 32'hFE7FFFF8, 0, 0, "R4 below window");
    send(0, 0, 4, 32'hFE800000, 0, 0, "R4 16B unchecked");
    // R5
    send(0, 0, 1, 32'h00001001, 0, 0, "R5 misaligned error");
    send(0, 0, 1, 32'h00001001, 1, 0, "R5 masked");
    send(0, 1, 2, 32'h00002003, 1, 0, "R5 write masked");
    // R6
    send(1, 0, 2, 32'h00000002, 0, 0, "R6 misaligned");
    send(1, 0, 2, 32'hFEFF0600, 0, 0, "R6 low window");
    send(1, 0, 2, 32'hFEFF05FC, 0, 0, "R6 gap");
    send(1, 0, 2, 32'hFEFF8000, 0, 0, "R6 above");
    send(1, 0, 0, 32'hFEFEFFFF, 0, 0, "R6 high window");
    send(1, 0, 3, 32'hFE800004, 0, 0, "R3 misaligned over error");
    // R7
    send(1, 0, 0, 32'hFE000000, 0, 0, "R7 low edge");
    send(1, 1, 0, 32'hFE7FFFFF, 0, 0, "R7 write high edge");
    send(1, 0, 0, 32'hFDFFFFFF, 0, 0, "R7 below");
    // R8
    send(2, 0, 2, 32'hFEFF0000, 0, 0, "R8 4B upper ok");
    send(2, 0, 3, 32'hFEFF0000, 0, 0, "R8 8B upper err");
    send(2, 0, 4, 32'hFEFFFFF0, 0, 0, "R8 16B upper err");
    send(2, 0, 0, 32'hFEFEFFFF, 0, 0, "R8 lower err");
    // R9
    send(2, 0, 0, 32'hFE3FFFFF, 0, 1, "R9 exc window");
    send(2, 0, 0, 32'hFE400000, 0, 1, "R9 reserved enabled");
    send(2, 0, 0, 32'hFE400000, 0, 0, "R9 reserved disabled");
    send(2, 0, 0, 32'hFE407FFF, 0, 0, "R9 reserved top");
    send(2, 0, 0, 32'hFE408000, 0, 1, "R9 upper exc");
    send(2, 0, 2, 32'h00000003, 0, 0, "R9 no align");
    // R10
    send(0, 1, 3, 32'hFE800000, 0, 0, "R10 A store error");
    send(1, 1, 2, 32'hFEFF0600, 0, 0, "R10 B store error");
    send(2, 1, 3, 32'hFEFF0008, 0, 0, "R10 C store error");
    send(1, 1, 1, 32'h00000011, 0, 0, "R10 B write misaligned");
    send(0, 1, 1, 32'hFE800001, 0, 0, "R10 A write falls to common");
    // R11
    send(0, 2, 2, 32'h00000102, 0, 0, "R11 misaligned");
    send(0, 2, 2, 32'hFEFFFFFC, 0, 0, "R11 window");
    send(0, 2, 2, 32'hFE7FFFFC, 0, 0, "R11 below");
    // R12
    send(1, 2, 2, 32'hFE800000, 0, 0, "R12 error");
    send(1, 2, 2, 32'hFEFF0600, 0, 0, "R12 error low");
    send(1, 2, 2, 32'hFE004000, 0, 1, "R12 exception");
    send(1, 2, 2, 32'hFE7FFFFC, 0, 1, "R12 exception top");
    send(1, 2, 2, 32'hFE003FFC, 0, 0, "R12 reserved off");
    send(1, 2, 2, 32'hFE003FFC, 0, 1, "R12 reserved on");
    send(1, 2, 2, 32'hFE003FFE, 0, 0, "R12 misaligned first");
    // R13
    send(2, 2, 2, 32'h00000007, 0, 0, "R13 silent align");
    send(2, 2, 2, 32'hFE800002, 0, 0, "R13 error after align");
    send(2, 2, 2, 32'hFE008000, 0, 1, "R13 exception");
    send(2, 2, 2, 32'hFE007FFC, 0, 0, "R13 reserved off");
    send(2, 2, 2, 32'hFE007FFC, 0, 1, "R13 reserved on");
    // R14
    send(3, 0, 3, 32'hFE800001, 0, 0, "R14 variant off");
    send(1, 3, 2, 32'hFE800002, 0, 0, "R14 kind none");
    idle_req();
    repeat (4) @(negedge clk);

    // Randomized sweep around window edges with back-pressure
    rand_bp = 1;
    for (int i = 0; i < 800; i++) begin
      logic [31:0] a;
      a = bases[$urandom_range(0, 11)] + 32'($urandom_range(0, 64)) - 32'd32;
      send(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 3'($urandom_range(0, 5)),
           a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R3 random sweep");
    end
    idle_req();
    rand_bp = 0;
    repeat (10) @(negedge clk);
    check(q_addr.size() == 0, "R1 all responses seen", 64'(q_addr.size()), 64'd0);
    check(rsp_valid == 1'b0 && rsp_fault == 0, "R2 final idle", {57'd0, rsp_valid, rsp_fault}, 64'd0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule